// File: doc/BRIEF.md
# Hash Engine Control Front-End

This block is the software-facing control layer of a hash accelerator. A processor uses a simple word-wide bus port to program four operand registers: where the message comes from, where the digest lives, where the key lives, and how many bytes to hash. It then writes a command word. The command word picks the algorithm, the accumulate mode and the big-endian digest handling. Writing the command while the engine is idle launches exactly one job. The block then gives a one-cycle start pulse to a separate compute datapath and waits for that datapath to report completion.

A status register shows a live busy bit, a sticky completion flag and a sticky overflow flag. The completion flag also drives an interrupt line. Both sticky flags are cleared by writing a 1 to them. Software is expected to clear the completion flag and to check that busy is low before it launches a job. The block protects itself anyway: a command written during a job is dropped. The operand registers feed the datapath directly. The algorithm and mode fields come from the last accepted command.

Top module: `hash_ctrl_frontend`

## Requirements
- R1: After reset, every mapped register reads zero: status 0x1C, source 0x20, digest 0x24, key 0x28, length 0x2C and command 0x30. The interrupt output and the start pulse are low.
- R2: The source, digest, key and length registers read back the last value written to them, and each one drives its matching datapath operand output.
- R3: A command write while idle with a recognised algorithm raises busy (status bit 0) and a single one-cycle start pulse in the cycle after the write.
- R4: Busy stays high until the datapath reports done. At that clock edge busy falls and the completion flag (status bit 9, also the interrupt output) is set, so with a datapath that answers L cycles after the start pulse, busy reads high for exactly L+2 cycles.
- R5: Writing 1 to status bit 9 clears the completion flag. Writing 0 to bit 9 leaves the flag unchanged.
- R6: A command write while busy is ignored. The command register keeps its value, no start pulse is produced and no flag changes.
- R7: The algorithm field is the set of command bits {10,6,5,4}. Pattern 0010 is SHA-1 (datapath code 0), 0101 is SHA-256 (code 1), 1110 is SHA-384 (code 2) and 0110 is SHA-512 (code 3). SHA-384 and SHA-512 differ only in bit 10.
- R8: A command with any other algorithm pattern is stored but produces no start pulse. Busy stays low, and the completion flag is set in the cycle after the write.
- R9: An overflow report from the datapath at completion sets status bit 23, which stays set until a 1 is written to bit 23. Clearing bit 9 alone does not clear it.
- R10: The accumulate output follows command bit 8 and the big-endian output follows command bit 3 of the last accepted command.
- R11: A done report from the datapath while the block is idle changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_done | output | 1 | Completion flag, level |
| dp_start | output | 1 | One-cycle job launch pulse |
| dp_algo | output | 2 | Algorithm code for the datapath |
| dp_accum | output | 1 | Accumulate mode |
| dp_be | output | 1 | Big-endian digest handling |
| dp_src | output | DATA_W | Message source address |
| dp_dst | output | DATA_W | Digest buffer address |
| dp_key | output | DATA_W | Key address |
| dp_len | output | DATA_W | Message byte length |
| dp_done | input | 1 | Datapath completion pulse |
| dp_ovf | input | 1 | Overflow report, valid with dp_done |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data is combinational, so a readback is taken a little after the next falling edge. The start pulse and busy appear in the cycle right after the command write. For an unrecognised code, the completion flag appears in that same cycle. The datapath stub answers a programmable L cycles after the start pulse, so the bench counts falling-edge samples with busy high and expects exactly L+2. At the sample where busy first reads low, it requires the completion flag to be set. Ignored stimuli are judged one cycle later, through status and command readback and a count of start pulses.

// File: rtl/hce_pkg.sv
`timescale 1ns/1ps
// Package: shared offsets, bit positions and the datapath algorithm code
// for the hash engine control front-end. Software depends on the offsets
// and bit positions, so they are fixed here rather than made parameters.
package hce_pkg;

    localparam int unsigned OFS_STATUS = 32'h1C;
    localparam int unsigned OFS_CMD    = 32'h30;

    // Operand registers: 0 source, 1 digest, 2 key, 3 length
    localparam int unsigned NUM_PTR = 4;
    localparam int unsigned PTR_OFS [NUM_PTR] = '{32'h20, 32'h24, 32'h28, 32'h2C};

    // Status bit positions
    localparam int unsigned ST_BUSY = 0;
    localparam int unsigned ST_DONE = 9;
    localparam int unsigned ST_OVF  = 23;

    // Command bit positions
    localparam int unsigned CMD_BE  = 3;
    localparam int unsigned CMD_ACC = 8;
    localparam int unsigned CMD_A0  = 4;
    localparam int unsigned CMD_A1  = 5;
    localparam int unsigned CMD_A2  = 6;
    localparam int unsigned CMD_A3  = 10;

    typedef enum logic [1:0] {
        ALG_SHA1   = 2'd0,
        ALG_SHA256 = 2'd1,
        ALG_SHA384 = 2'd2,
        ALG_SHA512 = 2'd3
    } hce_alg_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } hce_seq_e;

endpackage

// File: rtl/hce_algo_dec.sv
`timescale 1ns/1ps
// Module: hce_algo_dec
// Turns the four algorithm-select bits of a command word, ordered
// {bit10, bit6, bit5, bit4}, into a compact datapath code. It also flags
// whether the pattern is one of the four supported ones.
// Assumes: purely combinational, and the caller picks the bits.
module hce_algo_dec (
    input  logic [3:0]           sel_bits,
    output logic                 sel_valid,
    output hce_pkg::hce_alg_e    sel_code
);
    import hce_pkg::*;

    // Match the select pattern against the supported algorithms
    always_comb begin
        sel_valid = 1'b1;
        sel_code  = ALG_SHA1;
        unique case (sel_bits)
            4'b0010: sel_code = ALG_SHA1;
            4'b0101: sel_code = ALG_SHA256;
            4'b1110: sel_code = ALG_SHA384;
            4'b0110: sel_code = ALG_SHA512;
            default: sel_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/hce_regs.sv
`timescale 1ns/1ps
// Module: hce_regs
// Holds the operand registers and the command register, and provides the
// read mux for the whole register map.
// Assumes: single-cycle writes. Status is built outside and passed in.
// The command register only takes a write when cmd_wr_ok is high.
module hce_regs #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmd_wr_ok,
    input  logic [DATA_W-1:0] sts_word,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ptr_q [hce_pkg::NUM_PTR],
    output logic [DATA_W-1:0] cmd_q
);
    import hce_pkg::*;

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);

    genvar g;
    generate
        for (g = 0; g < NUM_PTR; g++) begin : g_ptr
            localparam logic [ADDR_W-1:0] A_PTR = ADDR_W'(PTR_OFS[g]);
            // Operand register g: plain read/write, cleared by reset
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ptr_q[g] <= '0;
                else if (we && addr == A_PTR)
                    ptr_q[g] <= wdata;
            end
        end
    endgenerate

    // Command register: takes a write only when the engine may start
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (we && addr == A_CMD && cmd_wr_ok)
            cmd_q <= wdata;
    end

    // Read mux: unmapped offsets read zero
    always_comb begin
        rdata = '0;
        if (addr == A_STATUS) rdata = sts_word;
        if (addr == A_CMD)    rdata = cmd_q;
        for (int i = 0; i < NUM_PTR; i++)
            if (addr == ADDR_W'(PTR_OFS[i])) rdata = ptr_q[i];
    end

endmodule

// File: rtl/hce_seq.sv
`timescale 1ns/1ps
// Module: hce_seq
// The job sequencer. It holds busy and the two sticky status flags, and
// issues the datapath start pulse.
// Assumes: launch is a command write, and launch_ok says whether its
// algorithm is recognised. Launches seen while running are dropped.
// A completion sets a flag in the same edge as any clear; the set wins.
module hce_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic launch_ok,
    input  logic dp_done,
    input  logic dp_ovf,
    input  logic clr_done,
    input  logic clr_ovf,
    output logic busy,
    output logic done_flag,
    output logic ovf_flag,
    output logic start_pulse
);
    import hce_pkg::*;

    hce_seq_e state_q, state_d;
    logic     start_d, set_done, set_ovf;

    // Next-state, start and flag-set decisions
    always_comb begin
        state_d  = state_q;
        start_d  = 1'b0;
        set_done = 1'b0;
        set_ovf  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (launch) begin
                    if (launch_ok) begin
                        state_d = SEQ_RUN;
                        start_d = 1'b1;
                    end else begin
                        set_done = 1'b1;
                    end
                end
            end
            SEQ_RUN: begin
                if (dp_done) begin
                    state_d  = SEQ_IDLE;
                    set_done = 1'b1;
                    set_ovf  = dp_ovf;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State, start pulse and sticky flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            start_pulse <= 1'b0;
            done_flag   <= 1'b0;
            ovf_flag    <= 1'b0;
        end else begin
            state_q     <= state_d;
            start_pulse <= start_d;
            done_flag   <= set_done | (done_flag & ~clr_done);
            ovf_flag    <= set_ovf  | (ovf_flag  & ~clr_ovf);
        end
    end

    assign busy = (state_q == SEQ_RUN);

endmodule

// File: rtl/hash_ctrl_frontend.sv
`timescale 1ns/1ps
// Module: hash_ctrl_frontend
// The top level: register map, job sequencer and algorithm decode for a
// hash accelerator, with a start/done handshake toward the compute datapath.
// Assumes: DATA_W >= 24 so that every status bit fits. The datapath holds
// dp_ovf valid in the cycle it raises dp_done.
module hash_ctrl_frontend #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_done,
    output logic              dp_start,
    output logic [1:0]        dp_algo,
    output logic              dp_accum,
    output logic              dp_be,
    output logic [DATA_W-1:0] dp_src,
    output logic [DATA_W-1:0] dp_dst,
    output logic [DATA_W-1:0] dp_key,
    output logic [DATA_W-1:0] dp_len,
    input  logic              dp_done,
    input  logic              dp_ovf
);
    import hce_pkg::*;

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);

    logic              seq_busy, seq_done, seq_ovf;
    logic              cmd_hit, sts_hit, wr_ok;
    logic [DATA_W-1:0] sts_word, cmd_q;
    logic [DATA_W-1:0] ptr_q [NUM_PTR];
    hce_alg_e          wr_code, cur_code;
    logic              cur_valid;

    assign cmd_hit = bus_we && (bus_addr == A_CMD);
    assign sts_hit = bus_we && (bus_addr == A_STATUS);

    // Status word assembly
    always_comb begin
        sts_word          = '0;
        sts_word[ST_BUSY] = seq_busy;
        sts_word[ST_DONE] = seq_done;
        sts_word[ST_OVF]  = seq_ovf;
    end

    hce_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .cmd_wr_ok (!seq_busy),
        .sts_word  (sts_word),
        .rdata     (bus_rdata),
        .ptr_q     (ptr_q),
        .cmd_q     (cmd_q)
    );

    // Decode of the command being written (decides launch vs. instant done)
    hce_algo_dec u_dec_wr (
        .sel_bits  ({bus_wdata[CMD_A3], bus_wdata[CMD_A2], bus_wdata[CMD_A1], bus_wdata[CMD_A0]}),
        .sel_valid (wr_ok),
        .sel_code  (wr_code)
    );

    // Decode of the stored command (drives the datapath algorithm code)
    hce_algo_dec u_dec_cur (
        .sel_bits  ({cmd_q[CMD_A3], cmd_q[CMD_A2], cmd_q[CMD_A1], cmd_q[CMD_A0]}),
        .sel_valid (cur_valid),
        .sel_code  (cur_code)
    );

    hce_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (cmd_hit),
        .launch_ok   (wr_ok),
        .dp_done     (dp_done),
        .dp_ovf      (dp_ovf),
        .clr_done    (sts_hit && bus_wdata[ST_DONE]),
        .clr_ovf     (sts_hit && bus_wdata[ST_OVF]),
        .busy        (seq_busy),
        .done_flag   (seq_done),
        .ovf_flag    (seq_ovf),
        .start_pulse (dp_start)
    );

    // Datapath-facing fields
    assign dp_algo  = cur_valid ? cur_code : ALG_SHA1;
    assign dp_accum = cmd_q[CMD_ACC];
    assign dp_be    = cmd_q[CMD_BE];
    assign dp_src   = ptr_q[0];
    assign dp_dst   = ptr_q[1];
    assign dp_key   = ptr_q[2];
    assign dp_len   = ptr_q[3];
    assign irq_done = seq_done;

    logic unused_code;
    assign unused_code = ^wr_code;

endmodule

// File: rtl/hce_ctrl_chk.sv
`timescale 1ns/1ps
// Module: hce_ctrl_chk
// Protocol checker bound to hash_ctrl_frontend. It watches the start pulse,
// busy, the sticky flags and the command register across clock edges.
// Assumes: synchronous active-low reset, with checks off while it is low.
module hce_ctrl_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              busy,
    input logic              done,
    input logic              ovf,
    input logic              dp_start,
    input logic              dp_done,
    input logic [DATA_W-1:0] cmd_q
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(hce_pkg::OFS_CMD);

    // R3
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |=> !dp_start);

    // R3
    start_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |-> busy);

    // R4
    finish_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dp_done) |=> (!busy && done));

    // R6
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we && bus_addr == A_CMD) |=> ($stable(cmd_q) && !dp_start));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !bus_we) |=> ($stable(done) && $stable(ovf) && !busy));

endmodule

bind hash_ctrl_frontend hce_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .busy     (seq_busy),
    .done     (seq_done),
    .ovf      (seq_ovf),
    .dp_start (dp_start),
    .dp_done  (dp_done),
    .cmd_q    (cmd_q)
);

// File: tb/hash_ctrl_frontend_tb.sv
`timescale 1ns/1ps
module hash_ctrl_frontend_tb;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_ST  = 8'h1C;
    localparam logic [AW-1:0] A_SRC = 8'h20;
    localparam logic [AW-1:0] A_DST = 8'h24;
    localparam logic [AW-1:0] A_KEY = 8'h28;
    localparam logic [AW-1:0] A_LEN = 8'h2C;
    localparam logic [AW-1:0] A_CMD = 8'h30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_done, dp_start, dp_accum, dp_be;
    logic [1:0]    dp_algo;
    logic [DW-1:0] dp_src, dp_dst, dp_key, dp_len;
    logic          stub_done = 1'b0;
    logic          inj_done = 1'b0;
    logic          stub_ovf_en = 1'b0;
    int            stub_lat = 1;
    int            stub_cnt = 0;
    int            n_starts = 0;
    int            n_checks = 0;
    int            n_fail = 0;
    logic          exp_ovf = 1'b0;

    always #10 clk = ~clk;

    hash_ctrl_frontend #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_done(irq_done),
        .dp_start(dp_start), .dp_algo(dp_algo), .dp_accum(dp_accum), .dp_be(dp_be),
        .dp_src(dp_src), .dp_dst(dp_dst), .dp_key(dp_key), .dp_len(dp_len),
        .dp_done(stub_done | inj_done), .dp_ovf(stub_done & stub_ovf_en)
    );

    // Datapath stub: pulses done stub_lat cycles after it sees the start pulse
    always @(posedge clk) begin
        stub_done <= 1'b0;
        if (dp_start) begin
            stub_cnt <= stub_lat;
            n_starts <= n_starts + 1;
        end else if (stub_cnt != 0) begin
            stub_cnt <= stub_cnt - 1;
            if (stub_cnt == 1) stub_done <= 1'b1;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic br(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        br(A_ST, v);  chk("R1 status", v, 0);
        br(A_SRC, v); chk("R1 src", v, 0);
        br(A_DST, v); chk("R1 dst", v, 0);
        br(A_KEY, v); chk("R1 key", v, 0);
        br(A_LEN, v); chk("R1 len", v, 0);
        br(A_CMD, v); chk("R1 cmd", v, 0);
        chk("R1 irq/start", {irq_done, dp_start}, 0);
    endtask

    task automatic t_operands();
        logic [DW-1:0] v;
        bw(A_SRC, 32'h1000_0040);
        bw(A_DST, 32'h2000_0080);
        bw(A_KEY, 32'hA5A5_5A5A);
        bw(A_LEN, 32'h0000_0123);
        br(A_SRC, v); chk("R2 src rb", v, 32'h1000_0040);
        br(A_DST, v); chk("R2 dst rb", v, 32'h2000_0080);
        br(A_KEY, v); chk("R2 key rb", v, 32'hA5A5_5A5A);
        br(A_LEN, v); chk("R2 len rb", v, 32'h0000_0123);
        chk("R2 dp operands", {dp_src ^ dp_dst, dp_key ^ dp_len},
            {32'h3000_00C0, 32'hA5A5_5B79});
    endtask

    // Launch one job and follow it to completion
    task automatic t_job(input logic [DW-1:0] cmd, input int lat, input logic ovf,
                         input logic [1:0] code);
        logic [DW-1:0] v;
        int starts0, bcnt;
        bw(A_ST, 32'h0000_0200);
        stub_lat = lat; stub_ovf_en = ovf;
        starts0 = n_starts;
        bw(A_CMD, cmd);
        br(A_ST, v);
        chk("R3 busy after write", {31'd0, v[0]}, 1);
        chk("R3 start pulse", {31'd0, dp_start}, 1);
        chk("R7 algo code", {30'd0, dp_algo}, {30'd0, code});
        chk("R10 accum/be", {dp_accum, dp_be}, {cmd[8], cmd[3]});
        bcnt = 0;
        for (int i = 0; i < 500; i++) begin
            br(A_ST, v);
            if (!v[0]) break;
            bcnt++;
            if (v[9]) chk("R4 done early", {31'd0, v[9]}, 0);
            @(negedge clk);
        end
        exp_ovf = exp_ovf | ovf;
        chk("R4 busy length", bcnt, lat + 2);
        chk("R4 done at finish", {31'd0, v[9]}, 1);
        chk("R4 irq", {31'd0, irq_done}, 1);
        chk("R9 ovf flag", {31'd0, v[23]}, {31'd0, exp_ovf});
        chk("R3 one start", n_starts - starts0, 1);
        stub_ovf_en = 1'b0;
    endtask

    task automatic t_clear();
        logic [DW-1:0] v;
        bw(A_ST, 32'h0000_0000);
        br(A_ST, v); chk("R5 write0 keeps", {v[23], v[9]}, {exp_ovf, 1'b1});
        bw(A_ST, 32'h0000_0200);
        br(A_ST, v); chk("R5/R9 clear done only", {v[23], v[9]}, {exp_ovf, 1'b0});
        bw(A_ST, 32'h0080_0000);
        exp_ovf = 1'b0;
        br(A_ST, v); chk("R9 ovf cleared", v, 0);
    endtask

    task automatic t_busy_write();
        logic [DW-1:0] v;
        int starts0;
        bw(A_ST, 32'h0080_0200);
        stub_lat = 20;
        starts0 = n_starts;
        bw(A_CMD, 32'h0000_0050);
        repeat (3) @(negedge clk);
        bw(A_CMD, 32'h0000_0128);
        br(A_CMD, v); chk("R6 cmd kept", v, 32'h50);
        br(A_ST, v);  chk("R6 flags unchanged", v, 32'h1);
        chk("R6 no second start", n_starts - starts0, 1);
        chk("R10 fields kept", {dp_accum, dp_be}, 0);
        for (int i = 0; i < 100; i++) begin
            br(A_ST, v);
            if (!v[0]) break;
            @(negedge clk);
        end
        chk("R6 single job done", v, 32'h200);
        chk("R6 start count end", n_starts - starts0, 1);
    endtask

    task automatic t_bad_algo();
        logic [DW-1:0] v;
        int starts0;
        bw(A_ST, 32'h0000_0200);
        starts0 = n_starts;
        bw(A_CMD, 32'h0000_0410);
        br(A_ST, v);  chk("R8 instant done no busy", v, 32'h200);
        br(A_CMD, v); chk("R8 cmd stored", v, 32'h410);
        @(negedge clk);
        chk("R8 no start", n_starts - starts0, 0);
    endtask

    task automatic t_stray_done();
        logic [DW-1:0] v;
        bw(A_ST, 32'h0080_0200);
        @(negedge clk); inj_done = 1'b1;
        @(negedge clk); inj_done = 1'b0;
        br(A_ST, v); chk("R11 idle done ignored", v, 0);
        chk("R11 irq low", {31'd0, irq_done}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_operands();
        t_job(32'h0000_0128, 1, 1'b0, 2'd0);  // SHA-1, accum, BE
        t_job(32'h0000_0050, 3, 1'b0, 2'd1);  // SHA-256
        t_job(32'h0000_0468, 5, 1'b1, 2'd2);  // SHA-384, overflow
        t_clear();
        t_job(32'h0000_0160, 2, 1'b0, 2'd3);  // SHA-512, accum
        t_busy_write();
        t_bad_algo();
        t_stray_done();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule